// File: doc/BRIEF.md
# Pipeline Hazard Unit (Forwarding and Load Interlock)

This block is the hazard controller for a five-stage in-order integer pipeline made of fetch, decode/register read, ALU, data memory and write-back. Every instruction, ALU operations included, writes the register file in the fifth stage. This gives the single write port exactly one writer per cycle. The decode stage gives the unit the fields of the instruction it holds: two source register numbers, a destination number, a write-enable and a load flag. The unit keeps its own copy of those control fields as the instruction moves through the ALU, memory and write-back stages.

From that copy it drives two outputs. The first is a pair of operand bypass selects for the instruction in the ALU stage. These choose between the register-file value, the ALU/memory pipeline register and the memory/write-back pipeline register. The second is a load-use interlock. When a load is in the ALU stage and the decode instruction reads its destination, `stall` goes high in the same cycle. The surrounding datapath then holds the PC and the fetch/decode register for that cycle. The unit itself loads a no-op, with its write-enable cleared, into its ALU-stage slot, and `bubble` marks that slot in the following cycle.

The register file is assumed to pass a same-cycle write through to a read. No bypass into decode is therefore needed. Branch delay slots are filled by the compiler, so the unit has no flush.

Top module: `pipe_hazard_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `stall` and `bubble` are 0 and both selects are 0.
- R2: Select encoding is 0 for the register file, 1 for the ALU/memory register and 2 for the memory/write-back register. An ALU-stage source equal to the non-zero destination of a write-enabled, non-load instruction one stage ahead selects 1.
- R3: An ALU-stage source equal to the non-zero destination of a write-enabled instruction two stages ahead selects 2, whether or not that instruction is a load.
- R4: When both older stages write the same register that an ALU-stage source reads, the younger one (select 1) wins.
- R5: Register 0 never causes a bypass or a stall.
- R6: An instruction with write-enable low is never a bypass source and never causes a stall, even when it is a load.
- R7: A write-enabled load in the ALU stage whose destination equals either decode source raises `stall` combinationally in that cycle.
- R8: A load-use stall lasts exactly one cycle. In the next cycle `bubble` is 1 and `stall` is 0. When the held consumer reaches the ALU stage, it selects 2 for the loaded register and `bubble` is 0.
- R9: Back-to-back dependent ALU instructions never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_rs1 | input | 5 | First source register of the decode instruction (0 if unused) |
| dec_rs2 | input | 5 | Second source register of the decode instruction (0 if unused) |
| dec_rd | input | 5 | Destination register of the decode instruction |
| dec_wr | input | 1 | Decode instruction writes the register file |
| dec_load | input | 1 | Decode instruction is a load |
| stall | output | 1 | Hold PC and fetch/decode register this cycle |
| bubble | output | 1 | ALU stage holds an inserted no-op |
| alu_sel_a | output | 2 | Bypass select for ALU operand A |
| alu_sel_b | output | 2 | Bypass select for ALU operand B |

## Verification
The interlock and the bypass meet in one cycle. While a consumer is held in decode behind a load, the ALU stage holds the bubble. In the very next cycle, the consumer's operand must come from the memory/write-back register that the load has just reached. The bench provokes this with a load followed directly by a dependent add. It checks that `stall` is high for that one cycle only, that `bubble` follows it, and that the consumer then reads select 2 with no second stall. A second case puts the same register in both older stages, so that the two bypass paths compete within one cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_stage_pipe.sv
// Control-field shadow of the ALU, memory and write-back stages.
module hz_stage_pipe #(
  parameter int AW = 5,
  parameter int NS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hold,
  input  logic [NS-1:0][AW-1:0] dec_src,
  input  logic [AW-1:0]         dec_rd,
  input  logic                  dec_we,
  input  logic                  dec_ld,
  output logic [NS-1:0][AW-1:0] ex_src,
  output logic [AW-1:0]         ex_rd,
  output logic                  ex_we,
  output logic                  ex_ld,
  output logic                  ex_bub,
  output logic [AW-1:0]         mem_rd,
  output logic                  mem_we,
  output logic                  mem_ld,
  output logic [AW-1:0]         wb_rd,
  output logic                  wb_we
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_src <= '0;
      ex_rd  <= '0;
      ex_we  <= 1'b0;
      ex_ld  <= 1'b0;
      ex_bub <= 1'b0;
      mem_rd <= '0;
      mem_we <= 1'b0;
      mem_ld <= 1'b0;
      wb_rd  <= '0;
      wb_we  <= 1'b0;
    end else begin
      if (hold) begin
        // inserted no-op: nothing read, nothing written
        ex_src <= '0;
        ex_rd  <= '0;
        ex_we  <= 1'b0;
        ex_ld  <= 1'b0;
      end else begin
        ex_src <= dec_src;
        ex_rd  <= dec_rd;
        ex_we  <= dec_we;
        ex_ld  <= dec_ld;
      end
      ex_bub <= hold;
      mem_rd <= ex_rd;
      mem_we <= ex_we;
      mem_ld <= ex_ld;
      wb_rd  <= mem_rd;
      wb_we  <= mem_we;
    end
  end
endmodule

// File: rtl/hz_load_interlock.sv
// Load-use detection between the ALU-stage load and the decode sources.
module hz_load_interlock #(
  parameter int AW = 5,
  parameter int NS = 2
) (
  input  logic [NS-1:0][AW-1:0] dec_src,
  input  logic [AW-1:0]         ex_rd,
  input  logic                  ex_we,
  input  logic                  ex_ld,
  output logic                  stall
);
  logic          ld_live;
  logic [NS-1:0] hit;

  assign ld_live = ex_we && ex_ld && (ex_rd != '0);

  for (genvar s = 0; s < NS; s++) begin : g_src
    assign hit[s] = ld_live && (dec_src[s] == ex_rd);
  end

  assign stall = |hit;
endmodule

// File: rtl/hz_bypass_sel.sv
// Bypass choice for one ALU-stage operand; the younger producer wins.
module hz_bypass_sel #(
  parameter int AW = 5
) (
  input  logic [AW-1:0]    src,
  input  logic [AW-1:0]    mem_rd,
  input  logic             mem_we,
  input  logic             mem_ld,
  input  logic [AW-1:0]    wb_rd,
  input  logic             wb_we,
  output hz_pkg::fwd_sel_e sel
);
  logic nz, mem_hit, wb_hit;

  assign nz      = (src != '0);
  // load data is not yet in the ALU/memory register
  assign mem_hit = nz && mem_we && !mem_ld && (mem_rd == src);
  assign wb_hit  = nz && wb_we && (wb_rd == src);

  always_comb begin
    if (mem_hit)     sel = hz_pkg::FWD_MEM;
    else if (wb_hit) sel = hz_pkg::FWD_WB;
    else             sel = hz_pkg::FWD_RF;
  end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dec_rs1,
  input  logic [AW-1:0] dec_rs2,
  input  logic [AW-1:0] dec_rd,
  input  logic          dec_wr,
  input  logic          dec_load,
  output logic          stall,
  output logic          bubble,
  output logic [1:0]    alu_sel_a,
  output logic [1:0]    alu_sel_b
);
  localparam int NS = 2;

  logic [NS-1:0][AW-1:0] dec_src, ex_src;
  logic [AW-1:0]         ex_rd, mem_rd, wb_rd;
  logic                  ex_we, ex_ld, ex_bub, mem_we, mem_ld, wb_we;
  logic                  hold;
  hz_pkg::fwd_sel_e      sel [NS];

  assign dec_src = {dec_rs2, dec_rs1};

  hz_load_interlock #(.AW(AW), .NS(NS)) u_lock (
    .dec_src (dec_src),
    .ex_rd   (ex_rd),
    .ex_we   (ex_we),
    .ex_ld   (ex_ld),
    .stall   (hold)
  );

  hz_stage_pipe #(.AW(AW), .NS(NS)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .hold    (hold),
    .dec_src (dec_src),
    .dec_rd  (dec_rd),
    .dec_we  (dec_wr),
    .dec_ld  (dec_load),
    .ex_src  (ex_src),
    .ex_rd   (ex_rd),
    .ex_we   (ex_we),
    .ex_ld   (ex_ld),
    .ex_bub  (ex_bub),
    .mem_rd  (mem_rd),
    .mem_we  (mem_we),
    .mem_ld  (mem_ld),
    .wb_rd   (wb_rd),
    .wb_we   (wb_we)
  );

  for (genvar s = 0; s < NS; s++) begin : g_byp
    hz_bypass_sel #(.AW(AW)) u_sel (
      .src    (ex_src[s]),
      .mem_rd (mem_rd),
      .mem_we (mem_we),
      .mem_ld (mem_ld),
      .wb_rd  (wb_rd),
      .wb_we  (wb_we),
      .sel    (sel[s])
    );
  end

  assign stall     = hold;
  assign bubble    = ex_bub;
  assign alu_sel_a = sel[0];
  assign alu_sel_b = sel[1];
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] dec_rs1,
  input logic [AW-1:0] dec_rs2,
  input logic          stall,
  input logic          bubble,
  input logic [1:0]    alu_sel_a,
  input logic [1:0]    alu_sel_b
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bubble && alu_sel_a == 2'd0 && alu_sel_b == 2'd0));

  a_r2_sel_legal: assert property (@(posedge clk) disable iff (rst)
    (alu_sel_a != 2'd3) && (alu_sel_b != 2'd3));

  a_r5_no_stall_r0: assert property (@(posedge clk) disable iff (rst)
    (dec_rs1 == '0 && dec_rs2 == '0) |-> !stall);

  a_r8_bubble_follows: assert property (@(posedge clk) disable iff (rst)
    stall |=> bubble);

  a_r8_single_stall: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);
endmodule

bind pipe_hazard_unit hz_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dec_rs1   (dec_rs1),
  .dec_rs2   (dec_rs2),
  .stall     (stall),
  .bubble    (bubble),
  .alu_sel_a (alu_sel_a),
  .alu_sel_b (alu_sel_b)
);

// File: tb/pipe_hazard_unit_tb.sv
`timescale 1ns/1ps
module pipe_hazard_unit_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] dec_rs1, dec_rs2, dec_rd;
  logic       dec_wr, dec_load;
  logic       stall, bubble;
  logic [1:0] alu_sel_a, alu_sel_b;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  logic       s_stall, s_bub;
  logic [1:0] s_fa, s_fb;

  always #10 clk = ~clk;

  pipe_hazard_unit u_dut (
    .clk(clk), .rst(rst),
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_rd(dec_rd),
    .dec_wr(dec_wr), .dec_load(dec_load),
    .stall(stall), .bubble(bubble),
    .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one decode slot; samples describe this decode and the ALU stage.
  task automatic issue(input logic [4:0] r1, input logic [4:0] r2,
                       input logic [4:0] rd, input logic we, input logic ld);
    @(negedge clk);
    dec_rs1 = r1; dec_rs2 = r2; dec_rd = rd; dec_wr = we; dec_load = ld;
    #2;
    s_stall = stall; s_bub = bubble; s_fa = alu_sel_a; s_fb = alu_sel_b;
    @(posedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) issue(0, 0, 0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    dec_rs1 = 0; dec_rs2 = 0; dec_rd = 0; dec_wr = 0; dec_load = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk("R1 stall in reset", stall, 0);
    chk("R1 bubble in reset", bubble, 0);
    rst = 1'b0;
    #2;
    chk("R1 sel_a", alu_sel_a, 0);
    chk("R1 sel_b", alu_sel_b, 0);
    chk("R1 bubble", bubble, 0);
  endtask

  task automatic t_alu_chain();
    drain();
    issue(1, 2, 3, 1'b1, 1'b0);         // r3 = r1 op r2
    issue(3, 4, 5, 1'b1, 1'b0);         // r5 = r3 op r4
    chk("R9 no stall back-to-back", s_stall, 0);
    issue(4, 3, 6, 1'b1, 1'b0);         // r6 = r4 op r3
    chk("R9 no stall second", s_stall, 0);
    chk("R2 sel_a from ALU/mem", s_fa, 1);
    chk("R2 sel_b register file", s_fb, 0);
    issue(0, 0, 0, 1'b0, 1'b0);
    chk("R3 sel_b from mem/wb", s_fb, 2);
    chk("R3 sel_a register file", s_fa, 0);
  endtask

  task automatic t_priority();
    drain();
    issue(0, 0, 3, 1'b1, 1'b0);
    issue(0, 0, 3, 1'b1, 1'b0);
    issue(3, 3, 7, 1'b1, 1'b0);
    issue(0, 0, 0, 1'b0, 1'b0);
    chk("R4 youngest wins a", s_fa, 1);
    chk("R4 youngest wins b", s_fb, 1);
  endtask

  task automatic t_load_use();
    drain();
    issue(2, 0, 7, 1'b1, 1'b1);         // load r7
    issue(9, 7, 8, 1'b1, 1'b0);         // r8 = r9 op r7
    chk("R7 stall on load-use", s_stall, 1);
    issue(9, 7, 8, 1'b1, 1'b0);         // held consumer again
    chk("R8 stall one cycle only", s_stall, 0);
    chk("R8 bubble after stall", s_bub, 1);
    issue(0, 0, 0, 1'b0, 1'b0);
    chk("R8 consumer sel_b from mem/wb", s_fb, 2);
    chk("R8 consumer sel_a register file", s_fa, 0);
    chk("R8 bubble cleared", s_bub, 0);
  endtask

  task automatic t_load_gap();
    drain();
    issue(2, 0, 7, 1'b1, 1'b1);         // load r7
    issue(2, 3, 1, 1'b1, 1'b0);         // independent
    chk("R7 no stall independent", s_stall, 0);
    issue(7, 0, 4, 1'b1, 1'b0);         // reads r7, one slot later
    chk("R7 no stall with gap", s_stall, 0);
    issue(0, 0, 0, 1'b0, 1'b0);
    chk("R3 load forwarded from mem/wb", s_fa, 2);
  endtask

  task automatic t_reg_zero();
    drain();
    issue(1, 1, 0, 1'b1, 1'b0);         // writes r0
    issue(0, 0, 5, 1'b1, 1'b0);         // reads r0
    issue(0, 0, 0, 1'b0, 1'b0);
    chk("R5 no bypass r0 a", s_fa, 0);
    chk("R5 no bypass r0 b", s_fb, 0);
    issue(1, 0, 0, 1'b1, 1'b1);         // load into r0
    issue(0, 0, 6, 1'b1, 1'b0);
    chk("R5 no stall load r0", s_stall, 0);
  endtask

  task automatic t_no_write();
    drain();
    issue(1, 0, 9, 1'b0, 1'b1);         // load-like, write disabled, rd r9
    issue(9, 9, 4, 1'b1, 1'b0);
    chk("R6 no stall without write", s_stall, 0);
    issue(0, 0, 0, 1'b0, 1'b0);
    chk("R6 no bypass without write", s_fa, 0);
  endtask

  task automatic t_load_rs2_only();
    drain();
    issue(0, 0, 12, 1'b1, 1'b1);        // load r12
    issue(3, 12, 2, 1'b1, 1'b0);
    chk("R7 stall via second source", s_stall, 1);
    issue(3, 12, 2, 1'b1, 1'b0);
    chk("R8 released", s_stall, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_alu_chain();
    t_priority();
    t_load_use();
    t_load_gap();
    t_reg_zero();
    t_no_write();
    t_load_rs2_only();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule